// File: doc/BRIEF.md
# Supervisor Status and Trap-State Register

This block holds the supervisor-level status word of a small processor core, together with the current privilege level of the hart. The privilege level is either user or supervisor. Software reads and writes the status word through a simple CSR port: write enable, write data and a read-data bus that always shows the current contents. Trap logic pulses a trap-entry strobe when it takes a trap and a trap-return strobe when it executes a supervisor return. On each strobe the block moves the interrupt-enable, saved-enable, saved-privilege and current-privilege state in a fixed order.

The block also decides whether a pending interrupt may be taken. It exports a user-width select code and a make-executable-readable control bit to the rest of the core. The supervisor width is a parameter. At 64 bits the user-width select is a writable field. At 32 bits that field does not exist and the user width is fixed at 32.

Status word layout: bit 0 is the interrupt enable, bit 1 the saved enable, bit 2 the saved privilege (0 user, 1 supervisor), bit 3 the make-executable-readable bit, and bits 5:4 the user-width code (64-bit build only). All other bits read zero.

Top module: `supStat`

## Requirements
- R1: After reset the privilege is supervisor (`privSuper`=1). Bits 3:0 read 0 and `mxrOut` is 0. In a 64-bit build bits 5:4 read 2 and `userWidthSel` is 2.
- R2: A CSR write with no trap strobe loads bit 0 (enable), bit 1 (saved enable), bit 2 (saved privilege) and bit 3 (make-executable-readable) from the write data. Bits above 5 always read 0.
- R3: On trap entry the saved-privilege bit takes the current privilege (0 from user, 1 from supervisor). The saved-enable bit takes the current enable, the enable clears, and the privilege becomes supervisor.
- R4: On trap return the enable takes the saved enable and the saved enable becomes 1. The privilege becomes user if the saved-privilege bit was 0 and supervisor if it was 1, and the saved-privilege bit clears to 0.
- R5: `irqTake` is high exactly when `irqPending` is high and either the privilege is user or the enable bit is set. In user mode the enable bit has no effect on `irqTake`.
- R6: The user-width code uses 1 for 32-bit and 2 for 64-bit. A write that carries any other code in bits 5:4 leaves the code unchanged. `userWidthSel` always shows the current code.
- R7: With the supervisor width set to 32, bits 5:4 read 0, writes to them have no effect, and `userWidthSel` stays 1.
- R8: `mxrOut` follows bit 3 of the status word.
- R9: When a trap strobe and a CSR write arrive in the same cycle, the trap update applies and the write is dropped. When both trap strobes arrive together, trap entry applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csrWrEn | input | 1 | CSR write enable |
| csrWrData | input | SUP_WIDTH | CSR write data |
| csrRdData | output | SUP_WIDTH | Current status word |
| trapEnter | input | 1 | Trap-entry strobe |
| trapReturn | input | 1 | Supervisor trap-return strobe |
| irqPending | input | 1 | An enabled interrupt source is pending |
| irqTake | output | 1 | Interrupt may be taken now |
| privSuper | output | 1 | Current privilege, 1 = supervisor, 0 = user |
| userWidthSel | output | 2 | User-mode width code (1 = 32, 2 = 64) |
| mxrOut | output | 1 | Make-executable-readable control |

## Verification
The assertions check on every cycle the following behaviours:
- The entry and return bit movements, including the saved enable moving into the enable bit on return.
- The rule that a supervisor-mode hart with the enable clear never takes an interrupt.
- The legality of the user-width code.
- The dominance of a trap strobe over a simultaneous CSR write.

Other behaviours only the bench scenarios can show:
- A round trip from user mode through a trap and back.
- The rejection of an illegal width code.
- The user-mode override of the enable bit.
- The different readback of the 32-bit build, which runs side by side with the 64-bit one on the same stimulus.

// File: rtl/supStatPkg.sv
package supStatPkg;
  localparam int IE_BIT  = 0;
  localparam int PIE_BIT = 1;
  localparam int PP_BIT  = 2;
  localparam int MXR_BIT = 3;
  localparam int UXL_LO  = 4;
  localparam int UXL_HI  = 5;

  localparam logic [1:0] WIDTH_CODE_32 = 2'd1;
  localparam logic [1:0] WIDTH_CODE_64 = 2'd2;

  typedef struct packed {
    logic doEnter;
    logic doReturn;
    logic doWrite;
  } ctlStrobes_t;
endpackage

// File: rtl/supStatCtrl.sv
module supStatCtrl
  import supStatPkg::*;
(
  input  logic        csrWrEn,
  input  logic        trapEnter,
  input  logic        trapReturn,
  input  logic        irqPending,
  input  logic        curIe,
  input  logic        curPriv,
  output ctlStrobes_t strb,
  output logic        irqTake
);
  always_comb begin
    strb          = '0;
    strb.doEnter  = trapEnter;
    strb.doReturn = trapReturn && !trapEnter;
    strb.doWrite  = csrWrEn && !trapEnter && !trapReturn;
  end

  assign irqTake = irqPending && (!curPriv || curIe);
endmodule

// File: rtl/supStatData.sv
module supStatData
  import supStatPkg::*;
#(
  parameter int SUP_WIDTH = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobes_t          strb,
  input  logic [SUP_WIDTH-1:0] wrData,
  output logic [SUP_WIDTH-1:0] rdData,
  output logic                 ie,
  output logic                 priv,
  output logic                 mxr,
  output logic [1:0]           uxl
);
  logic pie;
  logic pp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ie   <= 1'b0;
      pie  <= 1'b0;
      pp   <= 1'b0;
      mxr  <= 1'b0;
      priv <= 1'b1;
    end else if (strb.doEnter) begin
      pp   <= priv;
      pie  <= ie;
      ie   <= 1'b0;
      priv <= 1'b1;
    end else if (strb.doReturn) begin
      ie   <= pie;
      pie  <= 1'b1;
      priv <= pp;
      pp   <= 1'b0;
    end else if (strb.doWrite) begin
      ie  <= wrData[IE_BIT];
      pie <= wrData[PIE_BIT];
      pp  <= wrData[PP_BIT];
      mxr <= wrData[MXR_BIT];
    end
  end

  generate
    if (SUP_WIDTH >= 64) begin : g_uxlField
      logic [1:0] uxlReg;
      logic [1:0] newCode;
      logic       codeLegal;
      assign newCode   = wrData[UXL_HI:UXL_LO];
      assign codeLegal = (newCode == WIDTH_CODE_32) || (newCode == WIDTH_CODE_64);
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) uxlReg <= WIDTH_CODE_64;
        else if (strb.doWrite && codeLegal) uxlReg <= newCode;
      end
      assign uxl = uxlReg;
    end else begin : g_uxlFixed
      assign uxl = WIDTH_CODE_32;
    end
  endgenerate

  always_comb begin
    rdData          = '0;
    rdData[IE_BIT]  = ie;
    rdData[PIE_BIT] = pie;
    rdData[PP_BIT]  = pp;
    rdData[MXR_BIT] = mxr;
    if (SUP_WIDTH >= 64) rdData[UXL_HI:UXL_LO] = uxl;
  end
endmodule

// File: rtl/supStat.sv
module supStat
  import supStatPkg::*;
#(
  parameter int SUP_WIDTH = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 csrWrEn,
  input  logic [SUP_WIDTH-1:0] csrWrData,
  output logic [SUP_WIDTH-1:0] csrRdData,
  input  logic                 trapEnter,
  input  logic                 trapReturn,
  input  logic                 irqPending,
  output logic                 irqTake,
  output logic                 privSuper,
  output logic [1:0]           userWidthSel,
  output logic                 mxrOut
);
  ctlStrobes_t strb;
  logic        curIe;

  supStatCtrl u_ctrl (
    .csrWrEn   (csrWrEn),
    .trapEnter (trapEnter),
    .trapReturn(trapReturn),
    .irqPending(irqPending),
    .curIe     (curIe),
    .curPriv   (privSuper),
    .strb      (strb),
    .irqTake   (irqTake)
  );

  supStatData #(.SUP_WIDTH(SUP_WIDTH)) u_data (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .wrData(csrWrData),
    .rdData(csrRdData),
    .ie    (curIe),
    .priv  (privSuper),
    .mxr   (mxrOut),
    .uxl   (userWidthSel)
  );
endmodule

// File: rtl/supStatChk.sv
module supStatChk #(
  parameter int SUP_WIDTH = 64
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 csrWrEn,
  input logic [SUP_WIDTH-1:0] csrRdData,
  input logic                 trapEnter,
  input logic                 trapReturn,
  input logic                 irqPending,
  input logic                 irqTake,
  input logic                 privSuper,
  input logic [1:0]           userWidthSel,
  input logic                 mxrOut
);
  // R3: entry clears enable, saves it, enters supervisor
  p_enter_stack_r3: assert property (@(posedge clk) disable iff (!rstN)
    trapEnter |=> (!csrRdData[0] && privSuper && csrRdData[1] == $past(csrRdData[0])
                   && csrRdData[2] == $past(privSuper)));

  // R4: return restores enable, sets saved enable, restores privilege
  p_return_stack_r4: assert property (@(posedge clk) disable iff (!rstN)
    (trapReturn && !trapEnter) |=> (csrRdData[0] == $past(csrRdData[1]) && csrRdData[1]
                                   && !csrRdData[2] && privSuper == $past(csrRdData[2])));

  // R5: supervisor with enable clear never takes an interrupt
  p_no_take_masked_r5: assert property (@(posedge clk) disable iff (!rstN)
    (privSuper && !csrRdData[0]) |-> !irqTake);

  // R5: nothing taken without a pending interrupt
  p_no_take_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    !irqPending |-> !irqTake);

  // R6: width code always legal
  p_width_legal_r6: assert property (@(posedge clk) disable iff (!rstN)
    (userWidthSel == 2'd1) || (userWidthSel == 2'd2));

  // R9: write alongside a trap strobe leaves the control bit alone
  p_trap_over_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    (csrWrEn && (trapEnter || trapReturn)) |=> $stable(mxrOut));
endmodule

bind supStat supStatChk #(.SUP_WIDTH(SUP_WIDTH)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .csrWrEn     (csrWrEn),
  .csrRdData   (csrRdData),
  .trapEnter   (trapEnter),
  .trapReturn  (trapReturn),
  .irqPending  (irqPending),
  .irqTake     (irqTake),
  .privSuper   (privSuper),
  .userWidthSel(userWidthSel),
  .mxrOut      (mxrOut)
);

// File: tb/supStat_tb.sv
module supStat_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csrWrEn = 1'b0;
  logic [63:0] csrWrData = '0;
  logic        trapEnter = 1'b0;
  logic        trapReturn = 1'b0;
  logic        irqPending = 1'b0;
  logic [63:0] rd64;
  logic [31:0] rd32;
  logic        take64, take32, priv64, priv32, mxr64, mxr32;
  logic [1:0]  uxl64, uxl32;

  always #4 clk = ~clk;

  supStat #(.SUP_WIDTH(64)) u_dut (
    .clk(clk), .rstN(rstN), .csrWrEn(csrWrEn), .csrWrData(csrWrData),
    .csrRdData(rd64), .trapEnter(trapEnter), .trapReturn(trapReturn),
    .irqPending(irqPending), .irqTake(take64), .privSuper(priv64),
    .userWidthSel(uxl64), .mxrOut(mxr64)
  );

  supStat #(.SUP_WIDTH(32)) u_dut32 (
    .clk(clk), .rstN(rstN), .csrWrEn(csrWrEn), .csrWrData(csrWrData[31:0]),
    .csrRdData(rd32), .trapEnter(trapEnter), .trapReturn(trapReturn),
    .irqPending(irqPending), .irqTake(take32), .privSuper(priv32),
    .userWidthSel(uxl32), .mxrOut(mxr32)
  );

  typedef struct {
    logic [63:0] rd;
    logic        priv;
    logic        take;
    logic [1:0]  uxl;
    logic        mxr;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic mIe = 0, mPie = 0, mPp = 0, mMxr = 0, mPriv = 1;
  logic [1:0] mUxl = 2'd2;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic expItem_t mkItem(input logic irq, input string tag);
    expItem_t it;
    it.rd   = {58'b0, mUxl, mMxr, mPp, mPie, mIe};
    it.priv = mPriv;
    it.take = irq && (!mPriv || mIe);
    it.uxl  = mUxl;
    it.mxr  = mMxr;
    it.tag  = tag;
    return it;
  endfunction

  // driver: applies one cycle of stimulus, updates the model, pushes expectation
  task automatic doOp(input logic wr, input logic [63:0] data, input logic ent,
                      input logic ret, input logic irq, input string tag);
    @(negedge clk); #1;
    csrWrEn = wr; csrWrData = data; trapEnter = ent; trapReturn = ret;
    @(posedge clk);
    if (ent) begin
      mPp = mPriv; mPie = mIe; mIe = 0; mPriv = 1;
    end else if (ret) begin
      mIe = mPie; mPie = 1; mPriv = mPp; mPp = 0;
    end else if (wr) begin
      mIe = data[0]; mPie = data[1]; mPp = data[2]; mMxr = data[3];
      if (data[5:4] == 2'd1 || data[5:4] == 2'd2) mUxl = data[5:4];
    end
    #1;
    csrWrEn = 0; trapEnter = 0; trapReturn = 0; irqPending = irq;
    expQ.push_back(mkItem(irq, tag));
  endtask

  // monitor: compares at the falling edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      check(rd64 == e.rd, e.tag, "rd64", rd64, e.rd);
      check(priv64 == e.priv, e.tag, "priv64", {63'b0, priv64}, {63'b0, e.priv});
      check(take64 == e.take, e.tag, "take64", {63'b0, take64}, {63'b0, e.take});
      check(uxl64 == e.uxl, e.tag, "uxl64", {62'b0, uxl64}, {62'b0, e.uxl});
      check(mxr64 == e.mxr, e.tag, "mxr R8", {63'b0, mxr64}, {63'b0, e.mxr});
      // R7: 32-bit build hides the width field and pins the code at 1
      check(rd32 == {28'b0, e.rd[3:0]}, "R7", "rd32", {32'b0, rd32}, {60'b0, e.rd[3:0]});
      check(uxl32 == 2'd1, "R7", "uxl32", {62'b0, uxl32}, 64'd1);
      check(take32 == e.take, "R7", "take32", {63'b0, take32}, {63'b0, e.take});
    end
  end

  initial begin
    expItem_t r;
    repeat (3) @(posedge clk);
    rstN = 1;
    @(negedge clk);
    r = mkItem(1'b0, "R1");
    expQ.push_back(r);
    doOp(1, 64'h2B, 0, 0, 1, "R2");                 // ie,pie,mxr set; code 2
    doOp(1, 64'h1B, 0, 0, 1, "R6");                 // code 1
    doOp(1, 64'h31, 0, 0, 1, "R6");                 // illegal code 3 kept 1
    doOp(0, 64'h0,  1, 0, 1, "R3");                 // entry from supervisor
    doOp(0, 64'h0,  0, 1, 1, "R4");                 // return to supervisor
    doOp(1, 64'h12, 0, 0, 0, "R2");                 // pp=0, pie=1, ie=0
    doOp(0, 64'h0,  0, 1, 1, "R4");                 // return to user
    doOp(1, 64'h12, 0, 0, 1, "R5");                 // user, ie=0, still taken
    doOp(0, 64'h0,  1, 0, 1, "R3");                 // entry from user
    doOp(1, 64'h11, 0, 0, 1, "R5");                 // supervisor, ie=1
    doOp(1, 64'h2F, 1, 0, 1, "R9");                 // entry beats write
    doOp(1, 64'h2E, 0, 1, 0, "R9");                 // return beats write
    doOp(0, 64'h0,  1, 1, 1, "R9");                 // entry beats return
    doOp(0, 64'h0,  0, 0, 0, "R5");                 // nothing pending
    repeat (3) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule